// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the operation fields of a fetched 32-bit instruction into the full set of steering signals that a single-cycle processor datapath needs in the same cycle. It looks at the 6-bit major operation field and, for register-to-register instructions, the 6-bit function field. It also takes the zero flag from the ALU. From these it drives the register write enable, the destination register choice, the ALU B-operand choice, the memory write enable and the load write-back choice. It also drives the immediate extension mode, the branch and jump flags, the taken-branch PC select and a 3-bit ALU operation code.

The block is purely combinational and holds no state. The register file, ALU, memories and datapath multiplexers sit outside it. Nine instructions are recognised: five register-to-register operations (add, subtract, AND, OR, set-less-than), a word load, a word store, a branch-if-equal and an unconditional jump. Any other encoding is decoded as a harmless no-op. Such an encoding enables no write of any kind and no change of control flow, so no architectural state can change.

Top module: `ctl_decoder`

## Requirements
- R1: With op_code 6'b000000 and a recognised fn_code, wr_reg_en=1 and dst_is_rd=1, and alu_b_imm, wr_mem_en, load_to_reg, imm_signed, is_branch, is_jump and pc_take are all 0.
- R2: For op_code 6'b000000 the ALU code follows fn_code: 6'b100000 gives alu_op 3'b010, 6'b100010 gives 3'b110, 6'b100100 gives 3'b000, 6'b100101 gives 3'b001 and 6'b101010 gives 3'b111.
- R3: For the load opcode 6'b100011 the outputs are wr_reg_en=1, dst_is_rd=0, alu_b_imm=1, load_to_reg=1, imm_signed=1 and alu_op=3'b010, with wr_mem_en, is_branch and is_jump at 0.
- R4: For the store opcode 6'b101011 the outputs are wr_mem_en=1, alu_b_imm=1, imm_signed=1 and alu_op=3'b010, with wr_reg_en, load_to_reg, dst_is_rd, is_branch and is_jump at 0. wr_mem_en is never 1 for any other opcode.
- R5: For the branch opcode 6'b000100 the outputs are is_branch=1, imm_signed=1 and alu_op=3'b110 (subtract), with wr_reg_en, wr_mem_en, alu_b_imm, load_to_reg, dst_is_rd and is_jump at 0.
- R6: For the jump opcode 6'b000010 the outputs are is_jump=1 and alu_op=3'b010, with every other output at 0.
- R7: pc_take equals is_branch AND alu_zero, so it is 1 only for the branch opcode with alu_zero=1.
- R8: Any op_code other than the five listed, or op_code 6'b000000 with an fn_code other than the five listed, gives wr_reg_en, wr_mem_en, is_branch, is_jump, pc_take, alu_b_imm, load_to_reg and imm_signed all 0 and alu_op 3'b010. dst_is_rd stays 1 for op_code 6'b000000 and is 0 otherwise.
- R9: fn_code has no effect on any output when op_code is not 6'b000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Major operation field of the instruction |
| fn_code | input | 6 | Function field, meaningful for op_code 000000 |
| alu_zero | input | 1 | ALU result-is-zero flag |
| wr_reg_en | output | 1 | Register file write enable |
| dst_is_rd | output | 1 | 1 selects the rd field as write register, 0 selects rt |
| alu_b_imm | output | 1 | 1 routes the extended immediate to ALU input B |
| wr_mem_en | output | 1 | Data memory write enable |
| load_to_reg | output | 1 | 1 writes memory read data back instead of the ALU result |
| imm_signed | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| is_branch | output | 1 | Conditional branch instruction |
| is_jump | output | 1 | Unconditional jump instruction |
| pc_take | output | 1 | Next PC is the branch target |
| alu_op | output | 3 | ALU operation code |

## Verification
Two functions can land in the same cycle. One is the branch decision: the subtract code must go to the ALU while pc_take follows alu_zero. The other is the register-to-register path, where alu_zero may be high from an earlier compare but must not redirect the PC. The bench provokes both by sweeping every op_code and fn_code pair with alu_zero both low and high. Each sampled output vector is judged against a reference built from the requirement text. This makes a taken branch, a not-taken branch and an R-type result with a zero flag all occur on the same inputs, and none of them may leak into the others' outputs.

// File: rtl/ctl_decoder_pkg.sv
// Package: shared encodings and types for the instruction control decoder.
// Assumes a 32-bit instruction whose operation and function fields are 6 bits.
package ctl_decoder_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 3;

    // Major operation field values
    localparam logic [OP_W-1:0] OP_REG   = 6'b000000;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

    // Function field values for register-to-register instructions
    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    // ALU operation codes
    typedef enum logic [ALU_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_code_e;

    // How the ALU code is chosen
    typedef enum logic [1:0] {
        AM_ADD   = 2'd0,
        AM_SUB   = 2'd1,
        AM_FIELD = 2'd2
    } alu_mode_e;

    // Controls decided by the major operation field alone
    typedef struct packed {
        logic      reg_wr;
        logic      need_fn;
        logic      dst_rd;
        logic      b_imm;
        logic      mem_wr;
        logic      mem_to_reg;
        logic      sign_ext;
        logic      branch;
        logic      jump;
        alu_mode_e alu_mode;
    } main_ctl_t;

endpackage

// File: rtl/ctl_main_dec.sv
// Module: major-field decoder.
// Maps the 6-bit operation field to the controls that do not depend on the
// function field. Unknown encodings produce an all-inactive control set.
// Assumes: purely combinational, no state.
module ctl_main_dec
    import ctl_decoder_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output main_ctl_t       ctl_o
);

    // Purpose: select the control set for each recognised operation
    always_comb begin
        ctl_o = '{reg_wr: 1'b0, need_fn: 1'b0, dst_rd: 1'b0, b_imm: 1'b0,
                  mem_wr: 1'b0, mem_to_reg: 1'b0, sign_ext: 1'b0,
                  branch: 1'b0, jump: 1'b0, alu_mode: AM_ADD};
        unique case (op_i)
            OP_REG: begin
                ctl_o.reg_wr   = 1'b1;
                ctl_o.need_fn  = 1'b1;
                ctl_o.dst_rd   = 1'b1;
                ctl_o.alu_mode = AM_FIELD;
            end
            OP_LOAD: begin
                ctl_o.reg_wr     = 1'b1;
                ctl_o.b_imm      = 1'b1;
                ctl_o.mem_to_reg = 1'b1;
                ctl_o.sign_ext   = 1'b1;
            end
            OP_STORE: begin
                ctl_o.mem_wr   = 1'b1;
                ctl_o.b_imm    = 1'b1;
                ctl_o.sign_ext = 1'b1;
            end
            OP_BEQ: begin
                ctl_o.branch   = 1'b1;
                ctl_o.sign_ext = 1'b1;
                ctl_o.alu_mode = AM_SUB;
            end
            OP_JUMP: begin
                ctl_o.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_alu_dec.sv
// Module: ALU code decoder.
// Produces the 3-bit ALU code from the mode chosen by the major decoder and,
// in field mode, from the function field; flags whether that field is known.
// Assumes: purely combinational; an unknown field yields the add code.
module ctl_alu_dec
    import ctl_decoder_pkg::*;
(
    input  alu_mode_e        mode_i,
    input  logic [FN_W-1:0]  fn_i,
    output logic [ALU_W-1:0] alu_o,
    output logic             fn_ok_o
);

    alu_code_e field_code;
    logic      field_ok;

    // Purpose: decode the function field of register-to-register instructions
    always_comb begin
        field_ok   = 1'b1;
        field_code = ALU_ADD;
        unique case (fn_i)
            FN_ADD:  field_code = ALU_ADD;
            FN_SUB:  field_code = ALU_SUB;
            FN_AND:  field_code = ALU_AND;
            FN_OR:   field_code = ALU_OR;
            FN_SLT:  field_code = ALU_SLT;
            default: field_ok   = 1'b0;
        endcase
    end

    // Purpose: pick the final ALU code from the mode
    always_comb begin
        unique case (mode_i)
            AM_SUB:   alu_o = ALU_SUB;
            AM_FIELD: alu_o = field_code;
            default:  alu_o = ALU_ADD;
        endcase
        fn_ok_o = field_ok;
    end

endmodule

// File: rtl/ctl_pc_sel.sv
// Module: next-PC source select.
// The branch target is taken only when a branch is decoded and the ALU
// reports equal operands (zero result of the subtract).
// Assumes: combinational; the zero flag belongs to the current instruction.
module ctl_pc_sel (
    input  logic branch_i,
    input  logic zero_i,
    output logic take_o
);

    // Purpose: gate the branch flag with the compare result
    always_comb begin
        take_o = branch_i & zero_i;
    end

endmodule

// File: rtl/ctl_decoder.sv
// Module: top of the single-cycle instruction control decoder.
// Combines the major-field decoder, the ALU code decoder and the PC select.
// Register-to-register instructions with an unknown function field are
// squashed so that no register write takes place.
// Assumes: combinational; fields come straight from the fetched instruction.
module ctl_decoder
    import ctl_decoder_pkg::*;
(
    input  logic [OP_W-1:0]  op_code,
    input  logic [FN_W-1:0]  fn_code,
    input  logic             alu_zero,
    output logic             wr_reg_en,
    output logic             dst_is_rd,
    output logic             alu_b_imm,
    output logic             wr_mem_en,
    output logic             load_to_reg,
    output logic             imm_signed,
    output logic             is_branch,
    output logic             is_jump,
    output logic             pc_take,
    output logic [ALU_W-1:0] alu_op
);

    main_ctl_t main_ctl;
    logic      fn_ok;

    ctl_main_dec u_main (
        .op_i  (op_code),
        .ctl_o (main_ctl)
    );

    ctl_alu_dec u_alu (
        .mode_i  (main_ctl.alu_mode),
        .fn_i    (fn_code),
        .alu_o   (alu_op),
        .fn_ok_o (fn_ok)
    );

    ctl_pc_sel u_pc (
        .branch_i (main_ctl.branch),
        .zero_i   (alu_zero),
        .take_o   (pc_take)
    );

    // Purpose: drive the datapath controls, squashing unknown function codes
    always_comb begin
        wr_reg_en   = main_ctl.reg_wr & (~main_ctl.need_fn | fn_ok);
        dst_is_rd   = main_ctl.dst_rd;
        alu_b_imm   = main_ctl.b_imm;
        wr_mem_en   = main_ctl.mem_wr;
        load_to_reg = main_ctl.mem_to_reg;
        imm_signed  = main_ctl.sign_ext;
        is_branch   = main_ctl.branch;
        is_jump     = main_ctl.jump;
    end

endmodule

// File: rtl/ctl_decoder_chk.sv
// Module: assertion checker for the control decoder, bound to the top.
// Uses immediate assertions because the block is combinational; checks are
// skipped while any input is unknown.
module ctl_decoder_chk
    import ctl_decoder_pkg::*;
(
    input logic [OP_W-1:0]  op_code,
    input logic [FN_W-1:0]  fn_code,
    input logic             alu_zero,
    input logic             wr_reg_en,
    input logic             dst_is_rd,
    input logic             alu_b_imm,
    input logic             wr_mem_en,
    input logic             load_to_reg,
    input logic             imm_signed,
    input logic             is_branch,
    input logic             is_jump,
    input logic             pc_take,
    input logic [ALU_W-1:0] alu_op
);

    // Purpose: relate the outputs to the inputs whenever the inputs are known
    always_comb begin
        if (!$isunknown({op_code, fn_code, alu_zero})) begin
            // R4: memory write only for the store opcode
            a_r4_store_only: assert (!wr_mem_en || op_code == OP_STORE)
                else $error("a_r4_store_only");
            // R7: the PC is redirected only by an equal compare on a branch
            a_r7_take_needs_zero: assert (!pc_take || (alu_zero && op_code == OP_BEQ))
                else $error("a_r7_take_needs_zero");
            // R5: a branch always asks the ALU to subtract
            a_r5_branch_sub: assert (!is_branch || alu_op == 3'b110)
                else $error("a_r5_branch_sub");
            // R3: load write-back implies a register write of an address sum
            a_r3_load_path: assert (!load_to_reg || (wr_reg_en && alu_b_imm && alu_op == 3'b010))
                else $error("a_r3_load_path");
            // R8: at most one kind of state change per instruction
            a_r8_one_effect: assert ($onehot0({wr_reg_en, wr_mem_en, is_branch, is_jump}))
                else $error("a_r8_one_effect");
            // R1: register-to-register writes go to rd and use no immediate
            a_r1_reg_dst: assert (!(wr_reg_en && op_code == OP_REG) || (dst_is_rd && !alu_b_imm && !imm_signed))
                else $error("a_r1_reg_dst");
        end
    end

endmodule

bind ctl_decoder ctl_decoder_chk u_ctl_decoder_chk (
    .op_code     (op_code),
    .fn_code     (fn_code),
    .alu_zero    (alu_zero),
    .wr_reg_en   (wr_reg_en),
    .dst_is_rd   (dst_is_rd),
    .alu_b_imm   (alu_b_imm),
    .wr_mem_en   (wr_mem_en),
    .load_to_reg (load_to_reg),
    .imm_signed  (imm_signed),
    .is_branch   (is_branch),
    .is_jump     (is_jump),
    .pc_take     (pc_take),
    .alu_op      (alu_op)
);

// File: tb/ctl_decoder_bench.sv
// Bench: exhaustive sweep of op_code x fn_code x alu_zero against a reference
// built from the requirement text. Inputs change at the rising edge, outputs
// are sampled at the falling edge.
module ctl_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op_code = '0;
    logic [5:0] fn_code = '0;
    logic       alu_zero = 1'b0;
    logic       wr_reg_en, dst_is_rd, alu_b_imm, wr_mem_en, load_to_reg;
    logic       imm_signed, is_branch, is_jump, pc_take;
    logic [2:0] alu_op;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ctl_decoder u_ctl_decoder (
        .op_code     (op_code),
        .fn_code     (fn_code),
        .alu_zero    (alu_zero),
        .wr_reg_en   (wr_reg_en),
        .dst_is_rd   (dst_is_rd),
        .alu_b_imm   (alu_b_imm),
        .wr_mem_en   (wr_mem_en),
        .load_to_reg (load_to_reg),
        .imm_signed  (imm_signed),
        .is_branch   (is_branch),
        .is_jump     (is_jump),
        .pc_take     (pc_take),
        .alu_op      (alu_op)
    );

    // Output vector order: rw dst bimm mw m2r sx br jp pc alu[2:0]
    function automatic logic [11:0] expect_vec(input logic [5:0] op,
                                               input logic [5:0] fn,
                                               input logic z);
        logic rw = 0, dst = 0, bimm = 0, mw = 0, m2r = 0, sx = 0;
        logic br = 0, jp = 0;
        logic [2:0] alu = 3'b010;
        if (op == 6'b000000) begin
            dst = 1;
            rw  = 1;
            if      (fn == 6'b100000) alu = 3'b010;
            else if (fn == 6'b100010) alu = 3'b110;
            else if (fn == 6'b100100) alu = 3'b000;
            else if (fn == 6'b100101) alu = 3'b001;
            else if (fn == 6'b101010) alu = 3'b111;
            else rw = 0;
        end else if (op == 6'b100011) begin
            rw = 1; bimm = 1; m2r = 1; sx = 1;
        end else if (op == 6'b101011) begin
            mw = 1; bimm = 1; sx = 1;
        end else if (op == 6'b000100) begin
            br = 1; sx = 1; alu = 3'b110;
        end else if (op == 6'b000010) begin
            jp = 1;
        end
        return {rw, dst, bimm, mw, m2r, sx, br, jp, br & z, alu};
    endfunction

    function automatic string req_tag(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'b000000)
            return (fn == 6'b100000 || fn == 6'b100010 || fn == 6'b100100 ||
                    fn == 6'b100101 || fn == 6'b101010) ? "R1/R2" : "R8";
        if (op == 6'b100011) return "R3";
        if (op == 6'b101011) return "R4";
        if (op == 6'b000100) return "R5/R7";
        if (op == 6'b000010) return "R6";
        return "R8/R9";
    endfunction

    task automatic check_vec(input string tag);
        logic [11:0] got, exp;
        got = {wr_reg_en, dst_is_rd, alu_b_imm, wr_mem_en, load_to_reg,
               imm_signed, is_branch, is_jump, pc_take, alu_op};
        exp = expect_vec(op_code, fn_code, alu_zero);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%b fn=%b z=%b actual=%b expected=%b",
                     tag, op_code, fn_code, alu_zero, got, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
        @(posedge clk);
        op_code  <= op;
        fn_code  <= fn;
        alu_zero <= z;
        @(negedge clk);
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        // Reset-state inputs (all zero): R-type with unknown fn, squashed (R8)
        @(negedge clk);
        check_vec("R8 reset");
        // Directed: taken and not-taken branch (R5, R7)
        apply(6'b000100, 6'b111111, 1'b1);
        check_bit("R7 beq taken", pc_take, 1'b1);
        apply(6'b000100, 6'b000000, 1'b0);
        check_bit("R7 beq not taken", pc_take, 1'b0);
        // Directed: slt with zero high must not redirect (R7, R2)
        apply(6'b000000, 6'b101010, 1'b1);
        check_bit("R7 rtype no take", pc_take, 1'b0);
        check_bit("R2 slt code", alu_op == 3'b111, 1'b1);
        // Directed: store writes memory only (R4)
        apply(6'b101011, 6'b100000, 1'b0);
        check_bit("R4 store mem", wr_mem_en, 1'b1);
        check_bit("R4 store no reg", wr_reg_en, 1'b0);
        // Directed: jump (R6) and load (R3)
        apply(6'b000010, 6'b100100, 1'b1);
        check_bit("R6 jump", is_jump, 1'b1);
        apply(6'b100011, 6'b101010, 1'b0);
        check_bit("R3 load wb", load_to_reg, 1'b1);
        // Exhaustive sweep; fn varies under every opcode (R9)
        for (int o = 0; o < 64; o++) begin
            for (int f = 0; f < 64; f++) begin
                for (int z = 0; z < 2; z++) begin
                    apply(o[5:0], f[5:0], z[0]);
                    check_vec(req_tag(o[5:0], f[5:0]));
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule